// File: doc/BRIEF.md
# Word-Wide GPIO Register Block

This block is a parameterised general-purpose I/O controller that sits on a simple synchronous register bus. The bus has a word address, a write strobe, a read strobe, write data and read data. Every register is one word wide, and each bit of a register stands for one I/O line. Software drives the lines through an output latch and a direction register. It reads back either the latch or the sampled pin level for each line.

The latch can be changed in three ways. A data-register write loads every bit. A set-register write turns lines on. A clear-register write turns lines off. A build option removes the clear register; the set register then loads the whole latch. A second build option picks the polarity of the direction register, so a 1 means either "output" or "input". Two more options change how register bits relate to lines and to bus bytes: a mirrored bit order, and a big-endian byte order on the bus. A last option builds an input-only instance that ignores every write. Pins pass through a two-flop synchroniser before they are read.

Top module: `gpio_regbank`

## Requirements
- R1: `WIDTH` must be 8, 16, 32 or 64, and there are exactly `WIDTH` lines. A 64-bit instance must not enable byte swapping. Each register bit drives exactly one line, so writing a single 1 to the data register raises only that line's `pin_out`.
- R2: After reset, `pin_out` and `pin_oe` are all zero, so every line is an input. The direction register reads back the value that means "all inputs": all zeros in output polarity, all ones in input polarity.
- R3: A read at word offset 0 (data) returns, per line, the latch bit if the line is an output and the synchronised pin level if it is an input. A pin change becomes visible two clock edges after it is sampled. Read data is registered: it is valid in the cycle after the read strobe and is zero in any cycle that follows no read strobe.
- R4: A write at offset 1 (set) with the clear register present sets the latch bit of every line whose write bit is 1. Lines whose write bit is 0 are left unchanged.
- R5: A write at offset 2 (clear) clears the latch bit of every line whose write bit is 1. Lines whose write bit is 0 are left unchanged. A read at offset 2 returns 0.
- R6: When built without a clear register, a write at offset 1 loads the whole latch, so a 0 bit drives its line low. Offset 2 then reads 0 and ignores writes.
- R7: A write at offset 0 loads the whole output latch.
- R8: Offset 3 holds the direction register. In output polarity a 1 enables the line's output driver. In input polarity a 1 makes the line an input. A direction write leaves `pin_out` unchanged.
- R9: A read at offset 1 returns the output latch, whatever the line directions are.
- R10: With mirrored numbering, register bit `WIDTH-1-n` is line n in every register, for both reads and writes.
- R11: With byte swapping (16 or 32 bits), the bus word is the register with its bytes in reverse order. Mirroring, if also enabled, applies to the register after this byte reversal.
- R12: An input-only instance ignores writes to every register. It keeps `pin_out` and `pin_oe` at zero, and data reads return the synchronised pins.
- R13: Reads at offsets 4 and above return 0. Writes there change nothing. In any cycle without a write strobe, `pin_out` and `pin_oe` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | WIDTH | Write data in bus order |
| bus_rdata | output | WIDTH | Registered read data in bus order |
| pin_in | input | WIDTH | Asynchronous pin levels, line order |
| pin_out | output | WIDTH | Output latch, line order |
| pin_oe | output | WIDTH | Output enables, line order |

## Verification
A wrong latch or direction bit shows on `pin_out` or `pin_oe` at the first clock edge after the write that caused it. The set-register and data-register read-backs expose it again one cycle after a read strobe. A mapping fault, in bit mirroring or byte reversal, lands a write on the wrong line and returns read data in the wrong place. A missing or extra synchroniser stage shows as a pin change appearing one read too early or too late.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

   // Word offsets of the registers; software depends on this layout.
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_SET  = 1;
   localparam int unsigned OFS_CLR  = 2;
   localparam int unsigned OFS_DIR  = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_SET,
      SEL_CLR,
      SEL_DIR
   } reg_sel_e;

endpackage

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      for (genvar b = 0; b < W; b++) begin : g_line
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_rb_lanemap.sv
// Converts between bus order and line order.
// TO_LINES=1: bus -> line (byte reversal first, then bit mirror).
// TO_LINES=0: line -> bus (bit mirror first, then byte reversal).
module gpio_rb_lanemap #(
   parameter int unsigned W         = 32,
   parameter bit          MIRROR    = 1'b0,
   parameter bit          BYTE_SWAP = 1'b0,
   parameter bit          TO_LINES  = 1'b1
) (
   input  logic [W-1:0] in_word,
   output logic [W-1:0] out_word
);

   localparam int unsigned NBYTES = W / 8;

   logic [W-1:0] sw_in, sw_out, mr_in, mr_out;

   generate
      if (TO_LINES) begin : g_bus_to_line
         assign sw_in    = in_word;
         assign mr_in    = sw_out;
         assign out_word = mr_out;
      end else begin : g_line_to_bus
         assign mr_in    = in_word;
         assign sw_in    = mr_out;
         assign out_word = sw_out;
      end

      if (BYTE_SWAP) begin : g_swap
         for (genvar by = 0; by < NBYTES; by++) begin : g_byte
            for (genvar i = 0; i < 8; i++) begin : g_bit
               assign sw_out[8*by + i] = sw_in[8*(NBYTES-1-by) + i];
            end
         end
      end else begin : g_noswap
         assign sw_out = sw_in;
      end

      if (MIRROR) begin : g_mirror
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign mr_out[i] = mr_in[W-1-i];
         end
      end else begin : g_nomirror
         assign mr_out = mr_in;
      end
   endgenerate

endmodule

// File: rtl/gpio_rb_outctl.sv
module gpio_rb_outctl
   import gpio_rb_pkg::*;
#(
   parameter int unsigned W            = 32,
   parameter bit          HAS_CLEAR    = 1'b1,
   parameter bit          DIR_IS_INPUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  reg_sel_e     sel,
   input  logic         wr,
   input  logic [W-1:0] wline,
   output logic [W-1:0] latch,
   output logic [W-1:0] dir_bits,
   output logic [W-1:0] oe
);

   // Direction reset value that leaves every line an input.
   localparam logic [W-1:0] DIR_RST = DIR_IS_INPUT ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] latch_q, latch_nx, dir_q, dir_nx, set_val;

   generate
      if (HAS_CLEAR) begin : g_set_or
         assign set_val = latch_q | wline;
      end else begin : g_set_load
         assign set_val = wline;
      end

      if (DIR_IS_INPUT) begin : g_pol_in
         assign oe = ~dir_q;
      end else begin : g_pol_out
         assign oe = dir_q;
      end
   endgenerate

   always_comb begin
      latch_nx = latch_q;
      dir_nx   = dir_q;
      if (wr) begin
         case (sel)
            SEL_DATA: latch_nx = wline;
            SEL_SET:  latch_nx = set_val;
            SEL_CLR:  latch_nx = latch_q & ~wline;
            SEL_DIR:  dir_nx   = wline;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= DIR_RST;
      end else begin
         latch_q <= latch_nx;
         dir_q   <= dir_nx;
      end
   end

   assign latch    = latch_q;
   assign dir_bits = dir_q;

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_rb_pkg::*;
#(
   parameter int unsigned WIDTH        = 32,
   parameter int unsigned ADDR_W       = 4,
   parameter bit          MIRROR       = 1'b0,
   parameter bit          BYTE_SWAP    = 1'b0,
   parameter bit          HAS_CLEAR    = 1'b1,
   parameter bit          DIR_IS_INPUT = 1'b0,
   parameter bit          INPUT_ONLY   = 1'b0,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);

   // R1: elaboration-time legality checks
   generate
      if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
         $error("gpio_regbank: WIDTH must be 8, 16, 32 or 64");
      end
      if (WIDTH == 64 && BYTE_SWAP) begin : g_bad_swap
         $error("gpio_regbank: byte swapping is not available at 64 bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("gpio_regbank: ADDR_W must cover four register offsets");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_regbank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_eff;
   logic [WIDTH-1:0] wline, latch, dir_bits, oe_raw, oe, pin_sync;
   logic [WIDTH-1:0] rd_line, rd_bus;

   // Address decode; the clear offset only exists when built in.
   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == ADDR_W'(OFS_DATA))               sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(OFS_SET))           sel = SEL_SET;
      else if (bus_addr == ADDR_W'(OFS_CLR) && HAS_CLEAR) sel = SEL_CLR;
      else if (bus_addr == ADDR_W'(OFS_DIR))           sel = SEL_DIR;
   end

   assign wr_eff = bus_wr && !INPUT_ONLY;

   gpio_rb_lanemap #(
      .W(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(1'b1)
   ) u_wmap (
      .in_word (bus_wdata),
      .out_word(wline)
   );

   gpio_rb_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_sync)
   );

   gpio_rb_outctl #(
      .W(WIDTH), .HAS_CLEAR(HAS_CLEAR), .DIR_IS_INPUT(DIR_IS_INPUT)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr      (wr_eff),
      .wline   (wline),
      .latch   (latch),
      .dir_bits(dir_bits),
      .oe      (oe_raw)
   );

   assign oe = INPUT_ONLY ? '0 : oe_raw;

   // Read selection in line order.
   always_comb begin
      case (sel)
         SEL_DATA: rd_line = (oe & latch) | (~oe & pin_sync);
         SEL_SET:  rd_line = latch;
         SEL_DIR:  rd_line = dir_bits;
         default:  rd_line = '0;
      endcase
   end

   gpio_rb_lanemap #(
      .W(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP), .TO_LINES(1'b0)
   ) u_rmap (
      .in_word (rd_line),
      .out_word(rd_bus)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_bus;
      else             bus_rdata <= '0;
   end

   assign pin_out = latch;
   assign pin_oe  = oe;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
   import gpio_rb_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          HAS_CLEAR  = 1'b1,
   parameter bit          INPUT_ONLY = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe
);

   localparam bit SET_OR = HAS_CLEAR && !INPUT_ONLY;

   p_set_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_OR && bus_wr && bus_addr == ADDR_W'(OFS_SET))
      |=> ($countones(pin_out) >= $countones($past(pin_out))));

   p_set_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_OR && bus_wr && bus_addr == ADDR_W'(OFS_SET) && bus_wdata == '1)
      |=> (pin_out == '1));

   p_clr_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CLR))
      |=> ($countones(pin_out) <= $countones($past(pin_out))));

   p_clr_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_OR && bus_wr && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata == '1)
      |=> (pin_out == '0));

   p_dir_keeps_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> $stable(pin_out));

   p_rdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   p_unmapped_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr > ADDR_W'(OFS_DIR)) |=> (bus_rdata == '0));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_regbank gpio_regbank_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .HAS_CLEAR(HAS_CLEAR), .INPUT_ONLY(INPUT_ONLY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe)
);

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [2:0]  wr_v = '0;
   logic [2:0]  rd_v = '0;
   logic [31:0] pin_in = '0;

   logic [31:0] rdata0, out0, oe0;
   logic [15:0] rdata1, out1, oe1;
   logic [7:0]  rdata2, out2, oe2;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Line-order models
   logic [31:0] m_lat0 = '0, m_dir0 = '0;
   logic [15:0] m_lat1 = '0, m_dir1 = '1;

   always #(CLK_PERIOD/2) clk = ~clk;

   // u0: plain 32-bit, set/clear pair, output polarity
   gpio_regbank #(.WIDTH(32)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_v[0]), .bus_rd(rd_v[0]),
      .bus_wdata(wdata), .bus_rdata(rdata0), .pin_in(pin_in),
      .pin_out(out0), .pin_oe(oe0));

   // u1: 16-bit, mirrored, byte swapped, no clear register, input polarity
   gpio_regbank #(.WIDTH(16), .MIRROR(1'b1), .BYTE_SWAP(1'b1), .HAS_CLEAR(1'b0),
                  .DIR_IS_INPUT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_v[1]), .bus_rd(rd_v[1]),
      .bus_wdata(wdata[15:0]), .bus_rdata(rdata1), .pin_in(pin_in[15:0]),
      .pin_out(out1), .pin_oe(oe1));

   // u2: 8-bit, mirrored, input only
   gpio_regbank #(.WIDTH(8), .MIRROR(1'b1), .INPUT_ONLY(1'b1)) u2 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_v[2]), .bus_rd(rd_v[2]),
      .bus_wdata(wdata[7:0]), .bus_rdata(rdata2), .pin_in(pin_in[7:0]),
      .pin_out(out2), .pin_oe(oe2));

   function automatic logic [15:0] mir16(input logic [15:0] x);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = x[15-i];
      return r;
   endfunction

   function automatic logic [15:0] swp16(input logic [15:0] x);
      return {x[7:0], x[15:8]};
   endfunction

   function automatic logic [15:0] b2l1(input logic [15:0] x);
      return mir16(swp16(x));
   endfunction

   function automatic logic [15:0] l2b1(input logic [15:0] y);
      return swp16(mir16(y));
   endfunction

   function automatic logic [7:0] mir8(input logic [7:0] x);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = x[7-i];
      return r;
   endfunction

   function automatic logic [31:0] exp_rd0(input logic [3:0] a);
      case (a)
         4'd0:    return (m_dir0 & m_lat0) | (~m_dir0 & pin_in);
         4'd1:    return m_lat0;
         4'd3:    return m_dir0;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [15:0] exp_rd1(input logic [3:0] a);
      logic [15:0] oe;
      oe = ~m_dir1;
      case (a)
         4'd0:    return l2b1((oe & m_lat1) | (~oe & pin_in[15:0]));
         4'd1:    return l2b1(m_lat1);
         4'd3:    return l2b1(m_dir1);
         default: return 16'h0;
      endcase
   endfunction

   task automatic model_wr(input int k, input logic [3:0] a, input logic [31:0] d);
      logic [15:0] l1;
      if (k == 0) begin
         case (a)
            4'd0: m_lat0 = d;
            4'd1: m_lat0 = m_lat0 | d;
            4'd2: m_lat0 = m_lat0 & ~d;
            4'd3: m_dir0 = d;
            default: ;
         endcase
      end else if (k == 1) begin
         l1 = b2l1(d[15:0]);
         case (a)
            4'd0, 4'd1: m_lat1 = l1;
            4'd3:       m_dir1 = l1;
            default: ;
         endcase
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input int k, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_v  = 3'(1 << k);
      @(negedge clk);
      wr_v  = '0;
      model_wr(k, a, d);
   endtask

   task automatic bus_rd(input int k, input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      rd_v = 3'(1 << k);
      @(negedge clk);
      rd_v = '0;
      if (k == 0)      d = rdata0;
      else if (k == 1) d = {16'h0, rdata1};
      else             d = {24'h0, rdata2};
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      string       tag;
      int          k;
      logic [3:0]  a;

      pin_in = 32'h1234_5678;
      repeat (4) @(negedge clk);
      chk("R2 u0 out in reset", out0, 32'h0);
      chk("R2 u0 oe in reset", oe0, 32'h0);
      chk("R2 u1 oe in reset", {16'h0, oe1}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      bus_rd(0, 4'd0, d); chk("R2 u0 data reads pins", d, 32'h1234_5678);
      bus_rd(0, 4'd3, d); chk("R2 u0 dir reset", d, 32'h0);
      bus_rd(1, 4'd3, d); chk("R2 u1 dir reset input polarity", d, 32'h0000_FFFF);

      // R3: two-stage synchroniser latency
      @(negedge clk);
      pin_in = 32'hCAFE_0001;
      bus_rd(0, 4'd0, d); chk("R3 sync still old", d, 32'h1234_5678);
      bus_rd(0, 4'd0, d); chk("R3 sync new value", d, 32'hCAFE_0001);
      @(negedge clk);
      chk("R3 rdata zero when idle", rdata0, 32'h0);

      // R1: walking one through the data register
      for (int i = 0; i < 32; i++) begin
         bus_wr(0, 4'd0, 32'h1 << i);
         chk("R1 one line per bit", out0, 32'h1 << i);
      end

      bus_wr(0, 4'd0, 32'h0);
      bus_wr(0, 4'd1, 32'h0000_00F0); chk("R4 set", out0, 32'h0000_00F0);
      bus_wr(0, 4'd1, 32'h0000_000F); chk("R4 set keeps others", out0, 32'h0000_00FF);
      bus_wr(0, 4'd2, 32'h0000_0030); chk("R5 clear", out0, 32'h0000_00CF);
      bus_rd(0, 4'd2, d);             chk("R5 clear reads zero", d, 32'h0);
      bus_wr(0, 4'd0, 32'hA5A5_0000); chk("R7 data load", out0, 32'hA5A5_0000);
      bus_rd(0, 4'd1, d);             chk("R9 set reads latch", d, 32'hA5A5_0000);
      bus_wr(0, 4'd3, 32'hFFFF_0000); chk("R8 output polarity", oe0, 32'hFFFF_0000);
      chk("R8 dir write keeps out", out0, 32'hA5A5_0000);
      bus_rd(0, 4'd0, d);             chk("R3 mixed directions", d, 32'hA5A5_0001);
      bus_rd(0, 4'd5, d);             chk("R13 unmapped read", d, 32'h0);
      bus_wr(0, 4'd7, 32'hFFFF_FFFF); chk("R13 unmapped write out", out0, 32'hA5A5_0000);
      chk("R13 unmapped write oe", oe0, 32'hFFFF_0000);

      // u1: mirror + byte swap, no clear
      bus_wr(1, 4'd0, 32'h0001); chk("R11 swap+mirror low byte", {16'h0, out1}, 32'h0080);
      bus_wr(1, 4'd0, 32'h8000); chk("R11 swap+mirror high byte", {16'h0, out1}, 32'h0100);
      bus_wr(1, 4'd1, 32'hFFFF); chk("R6 set loads ones", {16'h0, out1}, 32'hFFFF);
      bus_wr(1, 4'd1, 32'h0000); chk("R6 set loads zeros", {16'h0, out1}, 32'h0000);
      bus_wr(1, 4'd1, 32'h00F0); chk("R6 set pattern", {16'h0, out1}, 32'h000F);
      bus_wr(1, 4'd2, 32'hFFFF); chk("R6 clear absent", {16'h0, out1}, 32'h000F);
      bus_rd(1, 4'd2, d);        chk("R6 clear offset reads zero", d, 32'h0);
      bus_rd(1, 4'd1, d);        chk("R9 u1 latch readback mapped", d, 32'h00F0);
      bus_wr(1, 4'd3, 32'h0000); chk("R8 input polarity all out", {16'h0, oe1}, 32'hFFFF);
      bus_wr(1, 4'd3, 32'h0001); chk("R8 input polarity one in", {16'h0, oe1}, 32'hFF7F);

      // u2: mirror only, input only
      bus_rd(2, 4'd0, d); chk("R10 mirrored pin read", d, 32'h80);
      for (int i = 0; i < 4; i++) bus_wr(2, 4'(i), 32'hFF);
      chk("R12 out stays zero", {24'h0, out2}, 32'h0);
      chk("R12 oe stays zero", {24'h0, oe2}, 32'h0);
      bus_rd(2, 4'd1, d); chk("R12 latch unchanged", d, 32'h0);
      bus_rd(2, 4'd3, d); chk("R12 dir unchanged", d, 32'h0);
      bus_rd(2, 4'd0, d); chk("R12 pins still read", d, 32'h80);

      // Constrained random mix
      void'($urandom(32'd17));
      for (int it = 0; it < 400; it++) begin
         if (($urandom % 16) == 0) begin
            @(negedge clk);
            pin_in = $urandom;
            repeat (3) @(negedge clk);
         end
         k = int'($urandom % 2);
         a = 4'($urandom % 5);
         case (a)
            4'd0: tag = "R7 random data";
            4'd1: tag = "R4 random set";
            4'd2: tag = "R5 random clear";
            4'd3: tag = "R8 random dir";
            default: tag = "R13 random unmapped";
         endcase
         if ($urandom % 2) begin
            bus_wr(k, a, $urandom);
            if (k == 0) begin
               chk(tag, out0, m_lat0);
               chk(tag, oe0, m_dir0);
            end else begin
               chk(tag, {16'h0, out1}, {16'h0, m_lat1});
               chk(tag, {16'h0, oe1}, {16'h0, ~m_dir1});
            end
         end else begin
            bus_rd(k, a, d);
            if (k == 0) chk(tag, d, exp_rd0(a));
            else        chk(tag, d, {16'h0, exp_rd1(a)});
         end
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule